// File: doc/BRIEF.md
# System Control Register Bank

This block is a word-addressed bank of board-level control and status registers. A processor reaches it over a simple register bus: a byte address whose two low bits are ignored, a write strobe, a read strobe, 32-bit write data and combinational 32-bit read data. The bank holds a fixed identity word and a fixed status word, two clock-oscillator setting registers that accept writes only after a 16-bit key has been written to a lock register, a control register, two flag registers with separate set and clear addresses, a memory-timing register, an init register and a read-only window of memory presence-detect bytes. The SDRAM register and the presence-detect bytes are filled from the memory-size parameter.

The control register drives three outputs. `led_on` follows a stored LED bit. `remap_ram` follows a stored remap bit: low leaves the boot flash overlaid at address zero, high removes the overlay so RAM shows there. `reset_req` is a one-cycle pulse that asks for a system reset. An access to an index the bank does not define reads as zero, changes no state and sets a sticky error flag.

Top module: `sysctl_bank`

## Requirements
- R1: Index 0 reads 0x411A3001 and index 4 reads 0x00100000. Both are read-only.
- R2: A write to the lock register (index 5) keeps only data bits 15:0. A read returns 0x0001A05F while the stored value is 0xA05F, and the stored value with bits 31:16 zero otherwise.
- R3: A write to the oscillator register (index 2) or the auxiliary oscillator register (index 7) updates it only while the stored lock value is 0xA05F. Otherwise the write is ignored.
- R4: The control register (index 3) stores data bits 0 and 2 and reads them in the same positions. Bits 1 and 3 and bits 31:4 read zero. `led_on` equals bit 0 and `remap_ram` equals bit 2.
- R5: A write to index 3 with data bit 3 set raises `reset_req` for exactly the one cycle after that write. At all other times `reset_req` is low.
- R6: A write to index 12 ORs the data into the flag register. A write to index 13 clears each flag bit that is set in the data. Index 12 reads the flags.
- R7: Indices 14 and 15 set and clear the non-volatile flag register in the same way as R6, and index 14 reads it. The two flag registers do not affect each other.
- R8: Reset values: oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init 0x00000112, lock 0, control 0, both flag registers 0, and all outputs low. SDRAM resets to 0x00011122 ORed with a size code: 0x10 for 256 MB or more, 0x0C for 128 MB or more, 0x08 for 64 MB or more, 0x04 for 32 MB or more, and 0 below that.
- R9: The SDRAM register (index 8) and the init register (index 9) store and return all 32 bits written to them.
- R10: Byte addresses 0x100 to 0x17F read presence-detect byte (address − 0x100)/4 in bits 7:0, with bits 31:8 zero. Byte 31 is 64, 32, 16, 4 or 2 for the size thresholds of R8, and byte 0 is 0x80. Addresses 0x180 to 0x1FF read zero. The window is read-only.
- R11: Indices 32 to 35 read zero, ignore writes and do not set the error flag.
- R12: A read or write of an index not defined for that direction returns zero on a read, changes no register and sets `access_err`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; used only for access-error tracking |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| led_on | output | 1 | LED level from control bit 0 |
| remap_ram | output | 1 | 1 removes the boot-flash overlay at address zero |
| reset_req | output | 1 | One-cycle system reset request |
| access_err | output | 1 | Sticky flag for an undefined access |

## Verification
Every stored register can be read back on the same bus. A wrong stored value therefore shows on `bus_rdata` at the first read of that index after the faulty write, with no added latency. A wrong lock state shows at once in the lock readback. It also shows one cycle later, when a write to a gated oscillator register is taken or dropped when it should not be. The control bits reach `led_on` and `remap_ram` in the cycle after the write. The reset pulse must appear in that same cycle and must be gone one cycle later.

// File: rtl/sysctl_pkg.sv
// Package: shared constants, register-select encoding and size-derived
// helper functions for the system control register bank.
// Assumes 32-bit bus data and a word-indexed register map.
package sysctl_pkg;

    localparam int WORD_W = 32;

    // Fixed read-only words and reset values
    localparam logic [WORD_W-1:0] ID_WORD    = 32'h411A_3001;
    localparam logic [WORD_W-1:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [WORD_W-1:0] OSC_RST    = 32'h0100_0048;
    localparam logic [WORD_W-1:0] AUX_RST    = 32'h0007_FEFF;
    localparam logic [WORD_W-1:0] INIT_RST   = 32'h0000_0112;
    localparam logic [WORD_W-1:0] SDRAM_BASE = 32'h0001_1122;
    localparam logic [15:0]       UNLOCK_KEY = 16'hA05F;

    // Word indices the bus decodes
    localparam int IDX_ID      = 0;
    localparam int IDX_OSC     = 2;
    localparam int IDX_CTRL    = 3;
    localparam int IDX_STAT    = 4;
    localparam int IDX_LOCK    = 5;
    localparam int IDX_AUX     = 7;
    localparam int IDX_SDRAM   = 8;
    localparam int IDX_INIT    = 9;
    localparam int IDX_FLG_SET = 12;
    localparam int IDX_FLG_CLR = 13;
    localparam int IDX_NVF_SET = 14;
    localparam int IDX_NVF_CLR = 15;
    localparam int IDX_VOLT_LO = 32;
    localparam int IDX_VOLT_HI = 35;
    localparam int IDX_SPD_LO  = 64;   // byte address 0x100
    localparam int SPD_LIVE    = 32;   // live bytes in the window
    localparam int SPD_SPAN    = 64;   // whole window in words

    // Control register bit positions
    localparam int CTRL_LED   = 0;
    localparam int CTRL_REMAP = 2;
    localparam int CTRL_RESET = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_OSC,
        SEL_CTRL,
        SEL_STAT,
        SEL_LOCK,
        SEL_AUX,
        SEL_SDRAM,
        SEL_INIT,
        SEL_FLG_SET,
        SEL_FLG_CLR,
        SEL_NVF_SET,
        SEL_NVF_CLR,
        SEL_VOLT,
        SEL_SPD
    } reg_sel_e;

    // SDRAM register size field from the memory size in MB
    function automatic logic [7:0] sdram_size_code(input int mem_mb);
        if (mem_mb >= 256)      return 8'h10;
        else if (mem_mb >= 128) return 8'h0C;
        else if (mem_mb >= 64)  return 8'h08;
        else if (mem_mb >= 32)  return 8'h04;
        else                    return 8'h00;
    endfunction

    // Presence-detect module-size byte from the memory size in MB
    function automatic logic [7:0] spd_size_byte(input int mem_mb);
        if (mem_mb >= 256)      return 8'd64;
        else if (mem_mb >= 128) return 8'd32;
        else if (mem_mb >= 64)  return 8'd16;
        else if (mem_mb >= 32)  return 8'd4;
        else                    return 8'd2;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Module: sysctl_decode
// Turns a word index into a register select. It also reports whether a
// read and whether a write are defined at that index, and gives the
// presence-detect byte number with a flag for the live part of the window.
// Assumes IDX_W is wide enough to reach the end of the presence-detect window.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] idx,
    output reg_sel_e         sel,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             spd_live,
    output logic [4:0]       spd_byte
);

    localparam int SPD_HI = IDX_SPD_LO + SPD_SPAN - 1;

    int unsigned widx;
    int unsigned woff;

    // Purpose: map the word index onto a register select
    always_comb begin
        widx = int'(idx);
        woff = widx - IDX_SPD_LO;
        sel  = SEL_NONE;
        if (widx == IDX_ID)                                   sel = SEL_ID;
        else if (widx == IDX_OSC)                             sel = SEL_OSC;
        else if (widx == IDX_CTRL)                            sel = SEL_CTRL;
        else if (widx == IDX_STAT)                            sel = SEL_STAT;
        else if (widx == IDX_LOCK)                            sel = SEL_LOCK;
        else if (widx == IDX_AUX)                             sel = SEL_AUX;
        else if (widx == IDX_SDRAM)                           sel = SEL_SDRAM;
        else if (widx == IDX_INIT)                            sel = SEL_INIT;
        else if (widx == IDX_FLG_SET)                         sel = SEL_FLG_SET;
        else if (widx == IDX_FLG_CLR)                         sel = SEL_FLG_CLR;
        else if (widx == IDX_NVF_SET)                         sel = SEL_NVF_SET;
        else if (widx == IDX_NVF_CLR)                         sel = SEL_NVF_CLR;
        else if (widx >= IDX_VOLT_LO && widx <= IDX_VOLT_HI)  sel = SEL_VOLT;
        else if (widx >= IDX_SPD_LO && widx <= SPD_HI)        sel = SEL_SPD;
    end

    // Purpose: locate the byte inside the presence-detect window
    always_comb begin
        spd_live = (sel == SEL_SPD) && (woff < SPD_LIVE);
        spd_byte = woff[4:0];
    end

    // Purpose: mark which selects accept each bus direction
    always_comb begin
        unique case (sel)
            SEL_ID, SEL_STAT, SEL_SPD: begin
                rd_ok = 1'b1; wr_ok = 1'b0;
            end
            SEL_FLG_CLR, SEL_NVF_CLR: begin
                rd_ok = 1'b0; wr_ok = 1'b1;
            end
            SEL_NONE: begin
                rd_ok = 1'b0; wr_ok = 1'b0;
            end
            default: begin
                rd_ok = 1'b1; wr_ok = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sysctl_spd_rom.sv
// Module: sysctl_spd_rom
// Read-only presence-detect bytes 0..31. Byte 31 is the module size,
// worked out from the MEM_MB parameter. Purely combinational.
module sysctl_spd_rom
    import sysctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic [4:0] byte_idx,
    output logic [7:0] byte_val
);

    localparam logic [7:0] SIZE_BYTE = spd_size_byte(MEM_MB);

    // Purpose: look up one presence-detect byte
    always_comb begin
        unique case (byte_idx)
            5'd0:  byte_val = 8'd128;
            5'd1:  byte_val = 8'd8;
            5'd2:  byte_val = 8'd4;
            5'd3:  byte_val = 8'd11;
            5'd4:  byte_val = 8'd9;
            5'd5:  byte_val = 8'd1;
            5'd6:  byte_val = 8'd64;
            5'd8:  byte_val = 8'd2;
            5'd9:  byte_val = 8'hA0;
            5'd10: byte_val = 8'hA0;
            5'd13: byte_val = 8'd8;
            5'd15: byte_val = 8'd1;
            5'd16: byte_val = 8'h0E;
            5'd17: byte_val = 8'd4;
            5'd18: byte_val = 8'h1C;
            5'd19: byte_val = 8'd1;
            5'd20: byte_val = 8'd2;
            5'd21: byte_val = 8'h20;
            5'd22: byte_val = 8'hC0;
            5'd27: byte_val = 8'h30;
            5'd28: byte_val = 8'h28;
            5'd29: byte_val = 8'h30;
            5'd30: byte_val = 8'h28;
            5'd31: byte_val = SIZE_BYTE;
            default: byte_val = 8'd0;
        endcase
    end

endmodule

// File: rtl/sysctl_setclr.sv
// Module: sysctl_setclr
// Flag register with separate set and clear strobes. Set ORs the data in and
// clear removes the data bits. Assumes the two strobes are never active in
// the same cycle; if they were, clear would win.
module sysctl_setclr #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;

    // Purpose: form the set and clear masks from the strobes
    always_comb begin
        set_mask = set_en ? data : '0;
        clr_mask = clr_en ? data : '0;
    end

    // Purpose: update the flags, clearing them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_mask) & ~clr_mask;
    end

endmodule

// File: rtl/sysctl_regs.sv
// Module: sysctl_regs
// Storage for the writable registers: the key-gated oscillators, the lock,
// the control bits with the registered reset pulse, SDRAM, init and both
// flag banks. Assumes wr_en is already qualified by a defined write index.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] osc_q,
    output logic [WORD_W-1:0] aux_q,
    output logic [WORD_W-1:0] sdram_q,
    output logic [WORD_W-1:0] init_q,
    output logic [15:0]       lock_q,
    output logic [WORD_W-1:0] flg_q,
    output logic [WORD_W-1:0] nvf_q,
    output logic              led_q,
    output logic              remap_q,
    output logic              rst_pulse_q
);

    localparam logic [WORD_W-1:0] SDRAM_RST =
        SDRAM_BASE | {{(WORD_W-8){1'b0}}, sdram_size_code(MEM_MB)};

    logic unlocked;

    // Purpose: the oscillator writes are open only while the key is held
    always_comb unlocked = (lock_q == UNLOCK_KEY);

    // Purpose: update the plain and key-gated registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q       <= OSC_RST;
            aux_q       <= AUX_RST;
            sdram_q     <= SDRAM_RST;
            init_q      <= INIT_RST;
            lock_q      <= '0;
            led_q       <= 1'b0;
            remap_q     <= 1'b0;
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= 1'b0;
            if (wr_en) begin
                unique case (sel)
                    SEL_OSC:   if (unlocked) osc_q <= wdata;
                    SEL_AUX:   if (unlocked) aux_q <= wdata;
                    SEL_LOCK:  lock_q <= wdata[15:0];
                    SEL_SDRAM: sdram_q <= wdata;
                    SEL_INIT:  init_q <= wdata;
                    SEL_CTRL: begin
                        led_q       <= wdata[CTRL_LED];
                        remap_q     <= wdata[CTRL_REMAP];
                        rst_pulse_q <= wdata[CTRL_RESET];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: one set/clear flag bank per flag register (0 volatile, 1 non-volatile)
    for (genvar g = 0; g < 2; g++) begin : g_flags
        localparam reg_sel_e SET_SEL = (g == 0) ? SEL_FLG_SET : SEL_NVF_SET;
        localparam reg_sel_e CLR_SEL = (g == 0) ? SEL_FLG_CLR : SEL_NVF_CLR;
        logic [WORD_W-1:0] bank_q;

        sysctl_setclr #(.WIDTH(WORD_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (wr_en && (sel == SET_SEL)),
            .clr_en (wr_en && (sel == CLR_SEL)),
            .data   (wdata),
            .q      (bank_q)
        );

        if (g == 0) begin : g_vol
            assign flg_q = bank_q;
        end else begin : g_nv
            assign nvf_q = bank_q;
        end
    end

endmodule

// File: rtl/sysctl_bank.sv
// Module: sysctl_bank (top)
// System control register bank on a word-addressed register bus. Reads are
// combinational from bus_addr. Writes take effect at the clock edge where
// bus_wr is high. An access to an index that is not defined for its
// direction is dropped and sets a sticky error flag.
// Assumes ADDR_W >= 9 so that the presence-detect window can be reached.
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              led_on,
    output logic              remap_ram,
    output logic              reset_req,
    output logic              access_err
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    reg_sel_e          sel;
    logic              rd_ok;
    logic              wr_ok;
    logic              spd_live;
    logic [4:0]        spd_byte;
    logic [7:0]        spd_val;
    logic [WORD_W-1:0] osc_q, aux_q, sdram_q, init_q, flg_q, nvf_q;
    logic [15:0]       lock_q;
    logic              led_q, remap_q, rst_pulse_q;
    logic              err_q;
    logic              unused_lo;

    assign word_idx  = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];

    sysctl_decode #(.IDX_W(IDX_W)) u_decode (
        .idx      (word_idx),
        .sel      (sel),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .spd_live (spd_live),
        .spd_byte (spd_byte)
    );

    sysctl_spd_rom #(.MEM_MB(MEM_MB)) u_spd (
        .byte_idx (spd_byte),
        .byte_val (spd_val)
    );

    sysctl_regs #(.MEM_MB(MEM_MB)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr && wr_ok),
        .sel         (sel),
        .wdata       (bus_wdata),
        .osc_q       (osc_q),
        .aux_q       (aux_q),
        .sdram_q     (sdram_q),
        .init_q      (init_q),
        .lock_q      (lock_q),
        .flg_q       (flg_q),
        .nvf_q       (nvf_q),
        .led_q       (led_q),
        .remap_q     (remap_q),
        .rst_pulse_q (rst_pulse_q)
    );

    // Purpose: choose the read word for the addressed register
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (sel)
                SEL_ID:      bus_rdata = ID_WORD;
                SEL_STAT:    bus_rdata = STAT_WORD;
                SEL_OSC:     bus_rdata = osc_q;
                SEL_AUX:     bus_rdata = aux_q;
                SEL_SDRAM:   bus_rdata = sdram_q;
                SEL_INIT:    bus_rdata = init_q;
                SEL_FLG_SET: bus_rdata = flg_q;
                SEL_NVF_SET: bus_rdata = nvf_q;
                SEL_LOCK:    bus_rdata = {15'd0, (lock_q == UNLOCK_KEY), lock_q};
                SEL_SPD:     bus_rdata = spd_live ? {24'd0, spd_val} : '0;
                SEL_CTRL: begin
                    bus_rdata[CTRL_LED]   = led_q;
                    bus_rdata[CTRL_REMAP] = remap_q;
                end
                default:     bus_rdata = '0;
            endcase
        end
    end

    // Purpose: latch any undefined access until reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                       err_q <= 1'b0;
        else if ((bus_wr && !wr_ok) || (bus_rd && !rd_ok)) err_q <= 1'b1;
    end

    assign led_on     = led_q;
    assign remap_ram  = remap_q;
    assign reset_req  = rst_pulse_q;
    assign access_err = err_q;

endmodule

// File: rtl/sysctl_bank_chk.sv
// Module: sysctl_bank_chk
// Concurrent checks on the bank's ports and stored state, attached by bind.
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              led_on,
    input logic              remap_ram,
    input logic              reset_req,
    input logic              access_err,
    input logic [31:0]       osc_q,
    input logic [31:0]       aux_q,
    input logic [15:0]       lock_q
);

    logic [ADDR_W-3:0] idx;
    logic              ctrl_wr;
    assign idx     = bus_addr[ADDR_W-1:2];
    assign ctrl_wr = bus_wr && (int'(idx) == IDX_CTRL);

    // R3: a locked write leaves the oscillator unchanged
    assert_osc_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(idx) == IDX_OSC && lock_q != UNLOCK_KEY) |=> $stable(osc_q));

    // R3: a locked write leaves the auxiliary oscillator unchanged
    assert_aux_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(idx) == IDX_AUX && lock_q != UNLOCK_KEY) |=> $stable(aux_q));

    // R4: the outputs move only on a control write
    assert_ctrl_outs_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable({led_on, remap_ram}));

    // R4: the reset bit and bit 1 always read zero
    assert_ctrl_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) == IDX_CTRL) |-> (bus_rdata[3] == 1'b0 && bus_rdata[1] == 1'b0));

    // R5: a reset-requesting write gives the pulse in the next cycle
    assert_reset_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CTRL_RESET]) |=> reset_req);

    // R5: the pulse appears only after such a write
    assert_reset_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(ctrl_wr && bus_wdata[CTRL_RESET]));

    // R10: the upper half of the presence-detect window reads zero
    assert_spd_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) >= IDX_SPD_LO + SPD_LIVE) |-> (bus_rdata == '0));

    // R12: the error flag never drops without reset
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> access_err);

endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .led_on     (led_on),
    .remap_ram  (remap_ram),
    .reset_req  (reset_req),
    .access_err (access_err),
    .osc_q      (osc_q),
    .aux_q      (aux_q),
    .lock_q     (lock_q)
);

// File: tb/tb_sysctl_bank.sv
// Bench for sysctl_bank: a vector table walked by one loop, followed by
// directed tests of reset, the control outputs and undefined accesses.
module tb_sysctl_bank;

    localparam int ADDR_W = 9;
    localparam int MEM_MB = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              led_on, remap_ram, reset_req, access_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sysctl_bank #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .led_on     (led_on),
        .remap_ram  (remap_ram),
        .reset_req  (reset_req),
        .access_err (access_err)
    );

    // Vector layout: {is_write, byte address, write data, expected read, requirement}
    localparam int NV = 44;
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 9'h000, 32'h0, 32'h411A3001, 4'd1},  // R1 identity
        {1'b0, 9'h010, 32'h0, 32'h00100000, 4'd1},  // R1 status
        {1'b0, 9'h008, 32'h0, 32'h01000048, 4'd8},  // R8 oscillator reset
        {1'b0, 9'h01C, 32'h0, 32'h0007FEFF, 4'd8},  // R8 aux reset
        {1'b0, 9'h024, 32'h0, 32'h00000112, 4'd8},  // R8 init reset
        {1'b0, 9'h020, 32'h0, 32'h0001112E, 4'd8},  // R8 SDRAM with 128 MB code
        {1'b0, 9'h014, 32'h0, 32'h00000000, 4'd8},  // R8 lock reset
        {1'b0, 9'h00C, 32'h0, 32'h00000000, 4'd8},  // R8 control reset
        {1'b1, 9'h008, 32'h12345678, 32'h0, 4'd3},  // R3 write while locked
        {1'b0, 9'h008, 32'h0, 32'h01000048, 4'd3},  // R3 write ignored
        {1'b1, 9'h014, 32'hFFFFA05F, 32'h0, 4'd2},  // R2 unlock key, upper bits dropped
        {1'b0, 9'h014, 32'h0, 32'h0001A05F, 4'd2},  // R2 unlocked readback
        {1'b1, 9'h008, 32'h12345678, 32'h0, 4'd3},  // R3
        {1'b0, 9'h008, 32'h0, 32'h12345678, 4'd3},  // R3 taken while unlocked
        {1'b1, 9'h01C, 32'hCAFE0001, 32'h0, 4'd3},  // R3
        {1'b0, 9'h01C, 32'h0, 32'hCAFE0001, 4'd3},  // R3
        {1'b1, 9'h014, 32'h00011234, 32'h0, 4'd2},  // R2 relock
        {1'b0, 9'h014, 32'h0, 32'h00001234, 4'd2},  // R2 low 16 bits only
        {1'b1, 9'h01C, 32'h00000000, 32'h0, 4'd3},  // R3
        {1'b0, 9'h01C, 32'h0, 32'hCAFE0001, 4'd3},  // R3 ignored after relock
        {1'b1, 9'h030, 32'h000000F0, 32'h0, 4'd6},  // R6 set
        {1'b1, 9'h030, 32'h00000F00, 32'h0, 4'd6},  // R6 set accumulates
        {1'b0, 9'h030, 32'h0, 32'h00000FF0, 4'd6},  // R6
        {1'b1, 9'h034, 32'h00000030, 32'h0, 4'd6},  // R6 clear
        {1'b0, 9'h030, 32'h0, 32'h00000FC0, 4'd6},  // R6
        {1'b1, 9'h038, 32'h000000A5, 32'h0, 4'd7},  // R7 set
        {1'b1, 9'h03C, 32'h00000005, 32'h0, 4'd7},  // R7 clear
        {1'b0, 9'h038, 32'h0, 32'h000000A0, 4'd7},  // R7
        {1'b0, 9'h030, 32'h0, 32'h00000FC0, 4'd7},  // R7 volatile flags untouched
        {1'b1, 9'h020, 32'h00005555, 32'h0, 4'd9},  // R9
        {1'b0, 9'h020, 32'h0, 32'h00005555, 4'd9},  // R9
        {1'b1, 9'h024, 32'h80000077, 32'h0, 4'd9},  // R9
        {1'b0, 9'h024, 32'h0, 32'h80000077, 4'd9},  // R9
        {1'b0, 9'h100, 32'h0, 32'h00000080, 4'd10}, // R10 byte 0
        {1'b0, 9'h104, 32'h0, 32'h00000008, 4'd10}, // R10 byte 1
        {1'b0, 9'h124, 32'h0, 32'h000000A0, 4'd10}, // R10 byte 9
        {1'b0, 9'h178, 32'h0, 32'h00000028, 4'd10}, // R10 byte 30
        {1'b0, 9'h17C, 32'h0, 32'h00000020, 4'd10}, // R10 byte 31, 128 MB
        {1'b0, 9'h180, 32'h0, 32'h00000000, 4'd10}, // R10 upper half
        {1'b0, 9'h1FC, 32'h0, 32'h00000000, 4'd10}, // R10 upper half end
        {1'b1, 9'h080, 32'hFFFFFFFF, 32'h0, 4'd11}, // R11 voltage write
        {1'b0, 9'h080, 32'h0, 32'h00000000, 4'd11}, // R11
        {1'b1, 9'h08C, 32'h12345678, 32'h0, 4'd11}, // R11
        {1'b0, 9'h08C, 32'h0, 32'h00000000, 4'd11}  // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state of the outputs
        check("R8 reset_req", {31'd0, reset_req}, 32'd0);
        check("R8 led_on", {31'd0, led_on}, 32'd0);
        check("R8 remap_ram", {31'd0, remap_ram}, 32'd0);
        check("R8 access_err", {31'd0, access_err}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][77]) begin
                bus_write(VEC[i][76:68], VEC[i][67:36]);
            end else begin
                bus_read(VEC[i][76:68], rd);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
            end
        end

        // R11 voltage accesses and all defined accesses leave the error flag clear
        check("R11 no error after defined accesses", {31'd0, access_err}, 32'd0);

        // R4 R5 control with all low bits set
        bus_write(9'h00C, 32'h0000000F);
        check("R5 pulse in cycle after write", {31'd0, reset_req}, 32'd1);
        check("R4 led_on set", {31'd0, led_on}, 32'd1);
        check("R4 remap_ram set", {31'd0, remap_ram}, 32'd1);
        @(negedge clk);
        check("R5 pulse lasts one cycle", {31'd0, reset_req}, 32'd0);
        bus_read(9'h00C, rd);
        check("R4 control readback", rd, 32'h00000005);
        check("R5 no pulse on read", {31'd0, reset_req}, 32'd0);

        bus_write(9'h00C, 32'h00000001);
        check("R5 no pulse without bit 3", {31'd0, reset_req}, 32'd0);
        check("R4 led only", {30'd0, remap_ram, led_on}, 32'd1);
        bus_write(9'h00C, 32'hFFFFFFF4);
        check("R4 remap only", {30'd0, remap_ram, led_on}, 32'd2);
        check("R5 no pulse, bit 3 clear", {31'd0, reset_req}, 32'd0);

        // R12 undefined read
        bus_read(9'h018, rd);
        check("R12 undefined read data", rd, 32'd0);
        check("R12 error flag set", {31'd0, access_err}, 32'd1);
        // R12 write to a read-only index, and a read of a write-only index
        bus_write(9'h000, 32'hDEADBEEF);
        bus_read(9'h000, rd);
        check("R12 R1 identity unchanged", rd, 32'h411A3001);
        bus_write(9'h110, 32'h000000FF);
        bus_read(9'h110, rd);
        check("R12 R10 window unchanged", rd, 32'h00000009);
        bus_read(9'h034, rd);
        check("R12 clear index reads zero", rd, 32'd0);
        repeat (3) @(negedge clk);
        check("R12 error flag sticky", {31'd0, access_err}, 32'd1);

        // R8 reset restores the stored state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R12 error cleared by reset", {31'd0, access_err}, 32'd0);
        check("R8 outputs after reset", {29'd0, reset_req, remap_ram, led_on}, 32'd0);
        bus_read(9'h008, rd);
        check("R8 oscillator after reset", rd, 32'h01000048);
        bus_read(9'h030, rd);
        check("R8 flags after reset", rd, 32'd0);
        bus_read(9'h038, rd);
        check("R8 non-volatile flags after reset", rd, 32'd0);

        finish_run();
    end

endmodule